// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount taken from a register operand and produces the result together with a carry flag. Four operations are supported: logical shift toward the top, logical shift toward the bottom, arithmetic shift toward the bottom, and rotation toward the bottom. Only the lowest eight bits of the amount register matter, so amounts from 0 to 255 are meaningful. Amounts of exactly the data width, amounts beyond it, and rotations by a nonzero multiple of the width each set the carry by a rule of their own.

A request is presented with a valid strobe. The result and the carry are captured one cycle later and held until the next strobe. When the amount leaves the carry undefined (an amount of zero), the incoming carry is passed to the output.

Top module: `rshift_carry`

## Requirements
- R1: Only bits [7:0] of `amt_reg` affect the result and the carry; higher bits are ignored.
- R2: With `op` 0 (logical left), a shift by n in 1..31 gives `data << n` and carry = data[32-n]; n = 32 gives 0 with carry = data[0]; n > 32 gives 0 with carry 0.
- R3: With `op` 1 (logical right), a shift by n in 1..31 gives `data >> n` and carry = data[n-1]; n = 32 gives 0 with carry = data[31]; n > 32 gives 0 with carry 0.
- R4: With `op` 2 (arithmetic right), a shift by n in 1..31 gives the sign-filled shift and carry = data[n-1]; n >= 32 gives all bits equal to data[31] and carry = data[31].
- R5: With `op` 3 (rotate right), the amount is taken modulo 32; a residue r in 1..31 gives the rotated value and carry = data[r-1].
- R6: A rotate whose 8-bit amount is nonzero but whose low five bits are zero returns `data` unchanged with carry = data[31].
- R7: An 8-bit amount of zero, for any `op`, returns `data` unchanged and passes `carry_in` to `carry_out`.
- R8: `result` and `carry_out` update only on the clock edge following a cycle with `valid_in` high, and hold otherwise; `valid_out` is high for exactly the cycle after each accepted request.
- R9: After reset, `result` is 0, `carry_out` is 0 and `valid_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| data_in | input | 32 | Operand to shift |
| amt_reg | input | 32 | Amount register; bits [7:0] used |
| op | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered shifted value |
| carry_out | output | 1 | Registered carry flag |
| valid_out | output | 1 | High the cycle after a request |

## Verification
A fault in the amount decode would show as a wrong result or carry on the very next cycle after a strobe, most visibly at the boundary amounts 0, 1, 31, 32, 33 and multiples of 32 for rotation. A stale output register shows as a value that changes without a strobe or fails to change with one, so results are compared every request and the outputs are also checked while idle. A carry selection fault often leaves the result correct, so the carry is compared independently on every request.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 8;

    typedef enum logic [1:0] {
        OP_LSL = 2'd0,
        OP_LSR = 2'd1,
        OP_ASR = 2'd2,
        OP_ROR = 2'd3
    } shop_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } shres_t;
endpackage

// File: rtl/rshift_core.sv
module rshift_core
    import rshift_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 8
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  shop_e         op,
    input  logic          carry_in,
    output logic [W-1:0]  value,
    output logic          carry
);
    localparam int unsigned SW = $clog2(W);

    logic [SW-1:0] low;
    logic          is_zero;
    logic          is_w;
    logic          over_w;
    logic [W-1:0]  lsl_v, lsr_v, asr_v, ror_v;
    logic [2*W-1:0] dbl;

    always_comb begin
        low     = amt[SW-1:0];
        is_zero = (amt == '0);
        is_w    = (amt == AW'(W));
        over_w  = (amt > AW'(W));
        lsl_v   = data << low;
        lsr_v   = data >> low;
        asr_v   = W'($signed(data) >>> low);
        dbl     = {data, data} >> low;
        ror_v   = dbl[W-1:0];

        value = data;
        carry = carry_in;
        if (!is_zero) begin
            unique case (op)
                OP_LSL: begin
                    if (is_w) begin
                        value = '0;
                        carry = data[0];
                    end else if (over_w) begin
                        value = '0;
                        carry = 1'b0;
                    end else begin
                        value = lsl_v;
                        carry = data[W-low];
                    end
                end
                OP_LSR: begin
                    if (is_w) begin
                        value = '0;
                        carry = data[W-1];
                    end else if (over_w) begin
                        value = '0;
                        carry = 1'b0;
                    end else begin
                        value = lsr_v;
                        carry = data[low-1];
                    end
                end
                OP_ASR: begin
                    if (is_w || over_w) begin
                        value = {W{data[W-1]}};
                        carry = data[W-1];
                    end else begin
                        value = asr_v;
                        carry = data[low-1];
                    end
                end
                default: begin
                    if (low == '0) begin
                        value = data;
                        carry = data[W-1];
                    end else begin
                        value = ror_v;
                        carry = data[low-1];
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (amt == '0) begin
            a_zero_pass_r7: assert (value == data && carry == carry_in);
        end
        if (op == OP_ROR && amt != '0 && amt[SW-1:0] == '0) begin
            a_ror_whole_r6: assert (value == data && carry == data[W-1]);
        end
        if ((op == OP_LSL || op == OP_LSR) && amt > AW'(W)) begin
            a_far_clear_r2: assert (value == '0 && carry == 1'b0);
        end
    end
endmodule

// File: rtl/rshift_carry.sv
module rshift_carry
    import rshift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_in,
    input  logic [31:0] data_in,
    input  logic [31:0] amt_reg,
    input  logic [1:0]  op,
    input  logic        carry_in,
    output logic [31:0] result,
    output logic        carry_out,
    output logic        valid_out
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              vld;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] core_v;
    logic              core_c;

    rshift_core #(.W(DATA_W), .AW(AMT_W)) u_core (
        .data     (data_in),
        .amt      (amt_reg[AMT_W-1:0]),
        .op       (shop_e'(op)),
        .carry_in (carry_in),
        .value    (core_v),
        .carry    (core_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (valid_in) begin
            st_d.res = core_v;
            st_d.cy  = core_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign carry_out = st_q.cy;
    assign valid_out = st_q.vld;

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(result) && $stable(carry_out)));
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    p_zero_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && amt_reg[7:0] == 8'd0) |=> (carry_out == $past(carry_in)));
endmodule

// File: tb/rshift_carry_test.sv
`timescale 1ns/1ps
module rshift_carry_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] data_in = '0;
    logic [31:0] amt_reg = '0;
    logic [1:0]  op = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        valid_out;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rshift_carry uut (.*);

    function automatic logic [32:0] model(input logic [31:0] d, input logic [31:0] a,
                                          input logic [1:0] o, input logic ci);
        int n;
        int r;
        n = int'(a[7:0]);
        if (n == 0) return {d, ci};
        case (o)
            2'd0: if (n < 32) return {d << n, d[32-n]};
                  else if (n == 32) return {32'd0, d[0]};
                  else return {32'd0, 1'b0};
            2'd1: if (n < 32) return {d >> n, d[n-1]};
                  else if (n == 32) return {32'd0, d[31]};
                  else return {32'd0, 1'b0};
            2'd2: if (n < 32) return {32'($signed(d) >>> n), d[n-1]};
                  else return {{32{d[31]}}, d[31]};
            default: begin
                r = n % 32;
                if (r == 0) return {d, d[31]};
                return {(d >> r) | (d << (32 - r)), d[r-1]};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] d, input logic [31:0] a,
                         input logic [1:0] o, input logic ci);
        logic [32:0] exp;
        exp = model(d, a, o, ci);
        @(negedge clk);
        data_in = d; amt_reg = a; op = o; carry_in = ci; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        tests++;
        if ({result, carry_out} !== exp || valid_out !== 1'b1) begin
            fails++;
            $display("FAIL %s: op=%0d amt=%0d got %h/%b/v%b expected %h/%b/v1",
                     req, o, a[7:0], result, carry_out, valid_out, exp[32:1], exp[0]);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] keep_r;
        logic        keep_c;
        repeat (3) @(negedge clk);
        tests++;
        if (result !== 0 || carry_out !== 0 || valid_out !== 0) begin
            fails++;
            $display("FAIL R9: got %h/%b/%b expected 0/0/0", result, carry_out, valid_out);
        end
        rst_n = 1'b1;

        // R2 boundaries
        check("R2", 32'h8000_0001, 32'd1, 2'd0, 1'b0);
        check("R2", 32'h8000_0001, 32'd31, 2'd0, 1'b0);
        check("R2", 32'hFFFF_FFFF, 32'd32, 2'd0, 1'b0);
        check("R2", 32'hFFFF_FFFF, 32'd33, 2'd0, 1'b1);
        // R3
        check("R3", 32'h8000_0001, 32'd1, 2'd1, 1'b0);
        check("R3", 32'h8000_0000, 32'd32, 2'd1, 1'b0);
        check("R3", 32'hFFFF_FFFF, 32'd200, 2'd1, 1'b1);
        // R4
        check("R4", 32'h8000_0010, 32'd5, 2'd2, 1'b0);
        check("R4", 32'h8000_0000, 32'd32, 2'd2, 1'b0);
        check("R4", 32'h7FFF_FFFF, 32'd255, 2'd2, 1'b1);
        // R5, R6
        check("R5", 32'h0000_0001, 32'd1, 2'd3, 1'b0);
        check("R5", 32'h1234_5678, 32'd36, 2'd3, 1'b0);
        check("R6", 32'h8000_0000, 32'd32, 2'd3, 1'b0);
        check("R6", 32'h0000_0001, 32'd64, 2'd3, 1'b1);
        // R7
        for (int o = 0; o < 4; o++) begin
            check("R7", 32'hDEAD_BEEF, 32'd0, 2'(o), 1'b1);
            check("R7", 32'hDEAD_BEEF, 32'd0, 2'(o), 1'b0);
        end
        // R1: upper bits ignored
        check("R1", 32'hF0F0_1234, 32'hFFFF_FF00, 2'd0, 1'b1);
        check("R1", 32'hF0F0_1234, 32'h1234_5604, 2'd1, 1'b0);
        check("R1", 32'hF0F0_1234, 32'hABCD_0020, 2'd3, 1'b0);

        // R8: hold while idle
        keep_r = result; keep_c = carry_out;
        @(negedge clk);
        data_in = 32'h5555_AAAA; amt_reg = 32'd3; op = 2'd1; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        tests++;
        if (result !== keep_r || carry_out !== keep_c || valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R8: got %h/%b/v%b expected %h/%b/v0",
                     result, carry_out, valid_out, keep_r, keep_c);
        end

        // random mix
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom();
            if (i % 3 == 0) a[7:0] = 8'($urandom_range(0, 40));
            check("R1-random", $urandom(), a, 2'($urandom_range(0, 3)), 1'($urandom()));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule